// File: doc/BRIEF.md
# Mode-Steered Eight-Pin Port Controller

This block controls one eight-pin port of a microcontroller. Three registers sit on a plain register bus: a write-only direction register, a data register that can be read and written, and a pull-up enable register that can be read and written. A 3-bit operating-mode input decides what the direction bits mean. Each pin can be a permanent address-bus output, an address output that software turns on per pin, or a general-purpose input/output pin driven from the data register.

For every pin the block produces an output enable, an output value, a pull-up enable and a source select that tells the pad whether the address bus or the data register drives it. Pin levels pass through a two-flop synchronizer before they reach the read path. The bus is a control path with no flow control. A write takes effect on the clock edge where `bus_req` and `bus_wr` are both high. Read data is combinational and valid in the same cycle as `bus_req` with `bus_wr` low. The mode is expected to change only while reset is asserted.

Top module: `mux_port`

## Requirements
- R1: Only the low 16 address bits are decoded. The direction register is at 0xFFC1, the data register at 0xFFC3 and the pull-up register at 0xFFD8. Bit i of each register belongs to pin i.
- R2: Reset is synchronous and active low. While reset is held, the direction register loads 0xFF when the mode is 0 to 4 and 0x00 when the mode is 5 to 7. The data and pull-up registers load 0x00 in every mode.
- R3: In modes 0 to 4, every pin has output enable 1 and source select 1 (address), and its output value equals its `addr_in` bit.
- R4: In modes 0 to 4, writes to the direction register have no effect, so every pin stays an address output.
- R5: A read of the direction register returns 0xFF in every mode.
- R6: In modes 5 and 6, a pin whose direction bit is 1 has output enable 1, source select 1, and drives its `addr_in` bit. A pin whose direction bit is 0 has output enable 0, source select 0, and output value equal to its data register bit.
- R7: In mode 7, every pin has source select 0 and drives its data register bit. Its output enable equals its direction bit.
- R8: A read of the data register returns the stored data bit for each pin whose effective direction is 1. For each pin whose effective direction is 0, it returns the pin level, which reflects `pin_in` after two clock edges.
- R9: The pull-up register reads back as written. A pin's pull-up enable is 1 only when its pull-up bit is 1, its effective direction is 0, and the mode is 5 to 7.
- R10: A write to any other address changes no register. A read of any other address returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 3 | Operating mode, 0 to 7 |
| bus_req | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Low 16 bits of the access address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| addr_in | input | 8 | Address-bus lines assigned to the pins |
| pin_in | input | 8 | Asynchronous pin levels |
| pin_oe | output | 8 | Per-pin output enable |
| pin_out | output | 8 | Per-pin output value |
| pin_pu | output | 8 | Per-pin pull-up enable |
| pin_src | output | 8 | Per-pin source select, 1 = address bus, 0 = data register |

## Verification
The bench builds the block with its default parameters: an 8-pin width, 16-bit decode at the three given addresses, and two synchronizer stages. With these settings every pin can be placed in each of the three mode classes by resetting under modes 0, 1, 4, 5, 6 and 7. Eight pins are few enough that random direction, data and pull-up patterns reach mixed masks, all-input and all-output patterns in a short run. The two-stage synchronizer makes the pin-to-readback delay a fixed two edges that the bench can wait out.

// File: rtl/mux_port_pkg.sv
package mux_port_pkg;

  typedef enum logic [1:0] {
    MC_ADDR_FIXED = 2'd0,
    MC_ADDR_SEL   = 2'd1,
    MC_GPIO       = 2'd2
  } mode_class_e;

  function automatic mode_class_e classify_mode(input logic [2:0] m);
    if (m == 3'd7)       return MC_GPIO;
    else if (m >= 3'd5)  return MC_ADDR_SEL;
    else                 return MC_ADDR_FIXED;
  endfunction

endpackage

// File: rtl/mux_port_sync.sv
module mux_port_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] pin_sync
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= {stg_q[STAGES-2:0], pin_in};
  end

  assign pin_sync = stg_q[LAST];

  // R8: the first stage follows the pin one edge later
  a_r8_first_stage: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> stg_q[0] == $past(pin_in));
endmodule

// File: rtl/mux_port_regs.sv
module mux_port_regs
  import mux_port_pkg::*;
#(
  parameter int          W         = 8,
  parameter int          AW        = 16,
  parameter logic [AW-1:0] ADDR_DIR  = 16'hFFC1,
  parameter logic [AW-1:0] ADDR_DATA = 16'hFFC3,
  parameter logic [AW-1:0] ADDR_PULL = 16'hFFD8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  mode_class_e   cls,
  input  logic          bus_req,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [W-1:0]  bus_wdata,
  input  logic [W-1:0]  pin_sync,
  output logic [W-1:0]  bus_rdata,
  output logic [W-1:0]  dir_eff,
  output logic [W-1:0]  data_q,
  output logic [W-1:0]  pull_q
);
  logic [W-1:0] dir_q;
  logic hit_dir, hit_data, hit_pull, any_hit, fixed, wr_en;

  assign hit_dir  = (bus_addr == ADDR_DIR);
  assign hit_data = (bus_addr == ADDR_DATA);
  assign hit_pull = (bus_addr == ADDR_PULL);
  assign any_hit  = hit_dir | hit_data | hit_pull;
  assign fixed    = (cls == MC_ADDR_FIXED);
  assign wr_en    = bus_req & bus_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q  <= fixed ? '1 : '0;
      data_q <= '0;
      pull_q <= '0;
    end else if (wr_en) begin
      if (hit_dir && !fixed) dir_q  <= bus_wdata;
      if (hit_data)          data_q <= bus_wdata;
      if (hit_pull)          pull_q <= bus_wdata;
    end
  end

  assign dir_eff = fixed ? '1 : dir_q;

  always_comb begin
    bus_rdata = '0;
    if (hit_dir)       bus_rdata = '1;
    else if (hit_data) bus_rdata = (dir_eff & data_q) | (~dir_eff & pin_sync);
    else if (hit_pull) bus_rdata = pull_q;
  end

  // R4: a direction write in the fixed modes leaves the register alone
  a_r4_dir_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (fixed && wr_en && hit_dir) |=> $stable(dir_q));

  // R10: a write that hits no register changes nothing
  a_r10_miss_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !any_hit) |=> ($stable(dir_q) && $stable(data_q) && $stable(pull_q)));

  // R10: a read of an undecoded address returns zero
  a_r10_miss_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_wr && !any_hit) |-> bus_rdata == '0);

  // R5: direction reads always return all ones
  a_r5_dir_reads_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_wr && hit_dir) |-> &bus_rdata);
endmodule

// File: rtl/mux_port_pins.sv
module mux_port_pins
  import mux_port_pkg::*;
#(
  parameter int W = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  mode_class_e cls,
  input  logic [W-1:0] dir_eff,
  input  logic [W-1:0] data_q,
  input  logic [W-1:0] pull_q,
  input  logic [W-1:0] addr_in,
  output logic [W-1:0] pin_oe,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_pu,
  output logic [W-1:0] pin_src
);
  logic addr_capable, pull_capable;

  assign addr_capable = (cls != MC_GPIO);
  assign pull_capable = (cls != MC_ADDR_FIXED);

  for (genvar i = 0; i < W; i++) begin : g_pin
    always_comb begin
      pin_src[i] = addr_capable & dir_eff[i];
      pin_oe[i]  = dir_eff[i];
      pin_out[i] = pin_src[i] ? addr_in[i] : data_q[i];
      pin_pu[i]  = pull_q[i] & ~dir_eff[i] & pull_capable;
    end
  end

  // R3: fixed modes drive every pin from the address bus
  a_r3_fixed_all_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (cls == MC_ADDR_FIXED) |-> (&pin_oe && &pin_src && pin_out == addr_in));

  // R7: single-chip mode never selects the address bus
  a_r7_gpio_no_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (cls == MC_GPIO) |-> (pin_src == '0 && pin_out == data_q));

  // R9: no pull-up on a driven pin
  a_r9_pull_inputs_only: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_pu & pin_oe) == '0);

  // R6: address source only on enabled pins
  a_r6_src_implies_oe: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_src & ~pin_oe) == '0);
endmodule

// File: rtl/mux_port.sv
module mux_port
  import mux_port_pkg::*;
#(
  parameter int            W           = 8,
  parameter int            AW          = 16,
  parameter int            SYNC_STAGES = 2,
  parameter logic [AW-1:0] ADDR_DIR    = 16'hFFC1,
  parameter logic [AW-1:0] ADDR_DATA   = 16'hFFC3,
  parameter logic [AW-1:0] ADDR_PULL   = 16'hFFD8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    mode,
  input  logic          bus_req,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  input  logic [W-1:0]  addr_in,
  input  logic [W-1:0]  pin_in,
  output logic [W-1:0]  pin_oe,
  output logic [W-1:0]  pin_out,
  output logic [W-1:0]  pin_pu,
  output logic [W-1:0]  pin_src
);
  mode_class_e  cls;
  logic [W-1:0] pin_sync, dir_eff, data_q, pull_q;

  assign cls = classify_mode(mode);

  mux_port_sync #(.W(W), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .pin_sync(pin_sync)
  );

  mux_port_regs #(
    .W(W), .AW(AW), .ADDR_DIR(ADDR_DIR), .ADDR_DATA(ADDR_DATA), .ADDR_PULL(ADDR_PULL)
  ) regs_i (
    .clk(clk), .rst_n(rst_n), .cls(cls),
    .bus_req(bus_req), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .pin_sync(pin_sync), .bus_rdata(bus_rdata),
    .dir_eff(dir_eff), .data_q(data_q), .pull_q(pull_q)
  );

  mux_port_pins #(.W(W)) pins_i (
    .clk(clk), .rst_n(rst_n), .cls(cls),
    .dir_eff(dir_eff), .data_q(data_q), .pull_q(pull_q), .addr_in(addr_in),
    .pin_oe(pin_oe), .pin_out(pin_out), .pin_pu(pin_pu), .pin_src(pin_src)
  );
endmodule

// File: tb/mux_port_tb_top.sv
module mux_port_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  mode = 3'd7;
  logic        bus_req = 1'b0, bus_wr = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0, addr_in = '0, pin_in = '0;
  logic [7:0]  bus_rdata, pin_oe, pin_out, pin_pu, pin_src;

  int checks = 0, errors = 0;
  logic [7:0] m_dir, m_data, m_pull;

  always #2 clk = ~clk;

  mux_port dut_i (
    .clk(clk), .rst_n(rst_n), .mode(mode), .bus_req(bus_req), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .addr_in(addr_in), .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out),
    .pin_pu(pin_pu), .pin_src(pin_src)
  );

  function automatic bit is_fixed(input logic [2:0] m); return m <= 3'd4; endfunction
  function automatic bit is_gpio(input logic [2:0] m);  return m == 3'd7; endfunction
  function automatic logic [7:0] e_dir();  return is_fixed(mode) ? 8'hFF : m_dir; endfunction
  function automatic logic [7:0] e_src();  return is_gpio(mode) ? 8'h00 : e_dir(); endfunction
  function automatic logic [7:0] e_out();  return (e_src() & addr_in) | (~e_src() & m_data); endfunction
  function automatic logic [7:0] e_pu();   return is_fixed(mode) ? 8'h00 : (m_pull & ~e_dir()); endfunction
  function automatic logic [7:0] e_read(input logic [15:0] a);
    case (a)
      16'hFFC1: return 8'hFF;
      16'hFFC3: return (e_dir() & m_data) | (~e_dir() & pin_in);
      16'hFFD8: return m_pull;
      default:  return 8'h00;
    endcase
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h mode=%0d", req, act, exp, mode);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic do_reset(input logic [2:0] m);
    @(negedge clk);
    rst_n = 1'b0; mode = m; bus_req = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_dir = is_fixed(m) ? 8'hFF : 8'h00; m_data = '0; m_pull = '0;
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_wr = 1'b0;
    case (a)
      16'hFFC1: if (!is_fixed(mode)) m_dir = d;
      16'hFFC3: m_data = d;
      16'hFFD8: m_pull = d;
      default: ;
    endcase
  endtask

  task automatic bus_read(input logic [15:0] a, output logic [7:0] v);
    @(negedge clk);
    bus_req = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 v = bus_rdata;
    bus_req = 1'b0;
  endtask

  task automatic set_pins(input logic [7:0] p);
    @(negedge clk);
    pin_in = p;
    repeat (3) @(negedge clk);
  endtask

  task automatic check_pins(input string req);
    @(negedge clk);
    #1;
    check({req, " oe"},  pin_oe,  e_dir());
    check({req, " src"}, pin_src, e_src());
    check({req, " out"}, pin_out, e_out());
    check({req, " pu"},  pin_pu,  e_pu());
  endtask

  task automatic check_read(input string req, input logic [15:0] a);
    logic [7:0] v;
    bus_read(a, v);
    check(req, v, e_read(a));
  endtask

  function automatic logic [15:0] pick_addr(input int k);
    case (k % 5)
      0: return 16'hFFC1;
      1: return 16'hFFC3;
      2: return 16'hFFD8;
      3: return 16'hFFC2;
      default: return 16'($urandom);
    endcase
  endfunction

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [2:0] modes [7] = '{3'd7, 3'd5, 3'd6, 3'd1, 3'd4, 3'd0, 3'd7};
    void'($urandom(32'h5EED));
    foreach (modes[mi]) begin
      do_reset(modes[mi]);
      addr_in = 8'hA5;
      // R2 reset values and R5 direction read
      check_read("R5 dir read after reset", 16'hFFC1);
      check_read("R2 pull reset", 16'hFFD8);
      set_pins(8'h3C);
      check_read("R2/R8 data reset read", 16'hFFC3);
      check_pins(is_fixed(mode) ? "R3 reset pins" : "R2 reset pins");
      // R4 direction write in fixed modes, R1 decode
      bus_write(16'hFFC1, 8'h0F);
      check_pins(is_fixed(mode) ? "R4 dir write ignored" : "R1 dir write");
      bus_write(16'hFFC3, 8'h96);
      check_read("R1/R8 data mixed", 16'hFFC3);
      bus_write(16'hFFD8, 8'hF3);
      check_read("R9 pull readback", 16'hFFD8);
      check_pins("R9 pull mixed");
      // R10 miss write and read
      bus_write(16'hFFC2, 8'h55);
      bus_write(16'h7FC3, 8'h55);
      check_read("R10 miss read", 16'hFFC0);
      check_read("R10 data unchanged", 16'hFFC3);
      check_read("R10 pull unchanged", 16'hFFD8);
      check_pins(is_gpio(mode) ? "R7 pins" : (is_fixed(mode) ? "R3 pins" : "R6 pins"));
      for (int n = 0; n < 120; n++) begin
        int op;
        op = int'($urandom % 4);
        case (op)
          0: bus_write(pick_addr(int'($urandom)), 8'($urandom));
          1: check_read("R8/R10 random read", pick_addr(int'($urandom)));
          2: set_pins(8'($urandom));
          default: begin
            @(negedge clk);
            addr_in = 8'($urandom);
          end
        endcase
        check_pins(is_gpio(mode) ? "R7 random pins" :
                   (is_fixed(mode) ? "R3 random pins" : "R6 random pins"));
      end
      check_read("R5 dir read end", 16'hFFC1);
    end
    finish_run();
  end
endmodule